// File: doc/BRIEF.md
# Crosspoint Configuration Command Controller

This controller sits between a narrow parallel configuration port and the control state of a crosspoint switch. Each configuration cycle carries a 4-bit opcode and two 7-bit fields, A and B. The controller samples them on the falling edge of the configuration clock whenever the active-low enable is low. It then turns the cycle into one of several actions: a clear of every connection, a broadcast overlay, a write of an output buffer setting, a connect, a disconnect, or a two-cycle status readback.

The controller holds the per-output source selection, the per-output buffer setting and the broadcast overlay. Every accepted write is also repeated for one cycle on a registered request channel, which the switch datapath consumes. A readback returns a 5-bit status word. Its top bit reports whether the addressed output is currently fed by the addressed input. Its low four bits hold the output's buffer setting.

Top module: `xcfg_ctrl`

## Requirements
- R1: A synchronous reset, taken on a falling clock edge, leaves rb at 0, req_vld at 0 and bc_on at 0, and no output connected to any input. Buffer settings are not reset.
- R2: Inputs are acted on only at falling clock edges where en_n is low. An edge with en_n high issues no request and changes no connection or buffer state.
- R3: Opcodes 0000, 0001 and 1000 to 1111 issue no request and change no state.
- R4: Opcode 0010 disconnects every output, cancels broadcast and leaves buffer settings unchanged. On the edge after it, req_vld is 1 and req_kind is 1.
- R5: Opcode 0011 with upd_n high and B below NPORT turns broadcast on with input B as source, and raises req_vld with req_kind 2. While broadcast is on, readback reports an output as connected only to that source.
- R6: upd_n low at a falling edge turns broadcast off, and readback again reports the programmed connections. A broadcast opcode seen while upd_n is low is ignored.
- R7: Opcode 0100 stores B[3:0] as the buffer setting of output A, with req_kind 3.
- R8: Opcode 0110 connects output A to input B (req_kind 4). Opcode 0111 disconnects output A (req_kind 5).
- R9: Opcode 0101 starts a readback of output A against input B. The next enabled cycle, whatever its opcode, is the second cycle. After that cycle rb = {connected, buffer setting[3:0]}.
- R10: If en_n is high at the edge after a readback's first cycle, the readback is dropped, and the next enabled cycle is decoded as a new command.
- R11: On writes, an A or B at or above NPORT suppresses the command. A readback with either address at or above NPORT returns 0.
- R12: rb becomes 0 after every enabled cycle other than a readback's second cycle, and holds its value across cycles with en_n high.
- R13: For every request, req_out carries A, req_in carries B and req_cfg carries B[3:0] of the cycle that caused it. The request appears one falling edge after that cycle and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg | input | 1 | Configuration clock, falling edge active |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low cycle enable |
| op | input | 4 | Opcode |
| fa | input | 7 | Field A: output address |
| fb | input | 7 | Field B: input address or setting data |
| upd_n | input | 1 | Global update, low ends broadcast |
| rb | output | 5 | Readback status |
| req_vld | output | 1 | Request strobe to the switch datapath |
| req_kind | output | 3 | Request type (1 clear, 2 broadcast, 3 buffer, 4 connect, 5 disconnect) |
| req_out | output | 7 | Output address of the request |
| req_in | output | 7 | Input address of the request |
| req_cfg | output | 4 | Buffer setting of the request |
| bc_on | output | 1 | Broadcast overlay active |

## Verification
The bench feeds a clear opcode into a readback's second cycle. A design that decoded that cycle as a command would lose the connections that the next readback expects. It also breaks a readback with a disabled gap and follows it with a buffer write. A controller that kept the readback pending would swallow that write and issue no request. Broadcast is checked in both directions. Readback must show only the broadcast source while the overlay is on, and the programmed map must return after upd_n goes low. A design that rewrote the stored map instead of overlaying it would fail that return. Addresses at 79, 80 and above catch an off-by-one range check, and reserved opcodes placed right after a nonzero readback catch an rb that fails to clear.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

  localparam logic [3:0] OP_CLR   = 4'b0010;
  localparam logic [3:0] OP_BCAST = 4'b0011;
  localparam logic [3:0] OP_BUFW  = 4'b0100;
  localparam logic [3:0] OP_RDBK  = 4'b0101;
  localparam logic [3:0] OP_CONN  = 4'b0110;
  localparam logic [3:0] OP_DISC  = 4'b0111;

  typedef enum logic [2:0] {
    RQ_NONE  = 3'd0,
    RQ_CLR   = 3'd1,
    RQ_BCAST = 3'd2,
    RQ_BUFW  = 3'd3,
    RQ_CONN  = 3'd4,
    RQ_DISC  = 3'd5
  } req_kind_e;

  // One strobe per decoded action, already gated by enable and range.
  typedef struct packed {
    logic clr;
    logic bcast;
    logic bufw;
    logic conn;
    logic disc;
    logic rd_first;
    logic rd_second;
  } dec_t;

endpackage

// File: rtl/xcfg_decode.sv
module xcfg_decode
  import xcfg_pkg::*;
#(
  parameter int NPORT = 80,
  parameter int AW    = 7
) (
  input  logic          en_n,
  input  logic [3:0]    op,
  input  logic [AW-1:0] fa,
  input  logic [AW-1:0] fb,
  input  logic          upd_n,
  input  logic          pend,
  output dec_t          dec,
  output logic          a_ok,
  output logic          b_ok
);

  localparam logic [AW:0] NP = (AW+1)'(NPORT);

  assign a_ok = {1'b0, fa} < NP;
  assign b_ok = {1'b0, fb} < NP;

  always_comb begin
    dec = '0;
    if (!en_n) begin
      if (pend) begin
        // second readback cycle: opcode field is not decoded
        dec.rd_second = 1'b1;
      end else begin
        case (op)
          OP_CLR:   dec.clr      = 1'b1;
          OP_BCAST: dec.bcast    = upd_n & b_ok;
          OP_BUFW:  dec.bufw     = a_ok;
          OP_RDBK:  dec.rd_first = 1'b1;
          OP_CONN:  dec.conn     = a_ok & b_ok;
          OP_DISC:  dec.disc     = a_ok;
          default:  dec          = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/xcfg_store.sv
module xcfg_store #(
  parameter int NPORT = 80,
  parameter int AW    = 7,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          bcast,
  input  logic          bufw,
  input  logic          conn,
  input  logic          disc,
  input  logic          rd_first,
  input  logic          a_ok,
  input  logic [AW-1:0] fa,
  input  logic [AW-1:0] fb,
  input  logic          upd_n,
  output logic [CW-1:0] rd_cfg,
  output logic          rd_vld,
  output logic [AW-1:0] rd_src,
  output logic          bc_on,
  output logic [AW-1:0] bc_src
);

  // Setting and source tables: one write, one registered read, no reset.
  logic [CW-1:0] cfg_mem [NPORT];
  logic [AW-1:0] src_mem [NPORT];
  logic [NPORT-1:0] vld;

  always_ff @(negedge clk) begin
    if (bufw) cfg_mem[fa] <= fb[CW-1:0];
    if (conn) src_mem[fa] <= fb;
    if (rd_first && a_ok) begin
      rd_cfg <= cfg_mem[fa];
      rd_src <= src_mem[fa];
    end
  end

  // Connection valid bits live in flops so a clear takes one cycle.
  for (genvar i = 0; i < NPORT; i++) begin : g_vld
    always_ff @(negedge clk) begin
      if (rst || clr)                     vld[i] <= 1'b0;
      else if (conn && fa == AW'(i))      vld[i] <= 1'b1;
      else if (disc && fa == AW'(i))      vld[i] <= 1'b0;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else if (rd_first && a_ok) rd_vld <= vld[fa];
  end

  // Broadcast is an overlay; the programmed map stays intact beneath it.
  always_ff @(negedge clk) begin
    if (rst || clr || !upd_n) begin
      bc_on  <= 1'b0;
      bc_src <= '0;
    end else if (bcast) begin
      bc_on  <= 1'b1;
      bc_src <= fb;
    end
  end

endmodule

// File: rtl/xcfg_rbseq.sv
module xcfg_rbseq #(
  parameter int AW = 7,
  parameter int CW = 4,
  localparam int RW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_n,
  input  logic          rd_first,
  input  logic          rd_second,
  input  logic          a_ok,
  input  logic          b_ok,
  input  logic [AW-1:0] fb,
  input  logic [CW-1:0] rd_cfg,
  input  logic          rd_vld,
  input  logic [AW-1:0] rd_src,
  input  logic          bc_on,
  input  logic [AW-1:0] bc_src,
  output logic          pend,
  output logic [RW-1:0] rb
);

  logic          rng_ok;
  logic [AW-1:0] want_in;
  logic          hit;
  logic [RW-1:0] status;

  always_comb begin
    hit    = bc_on ? (bc_src == want_in) : (rd_vld && rd_src == want_in);
    status = rng_ok ? {hit, rd_cfg} : '0;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      rng_ok  <= 1'b0;
      want_in <= '0;
      rb      <= '0;
    end else if (en_n) begin
      pend <= 1'b0;                       // gap drops a pending readback
    end else begin
      pend <= rd_first;
      if (rd_first) begin
        rng_ok  <= a_ok & b_ok;
        want_in <= fb;
      end
      rb <= rd_second ? status : '0;
    end
  end

endmodule

// File: rtl/xcfg_ctrl.sv
module xcfg_ctrl
  import xcfg_pkg::*;
#(
  parameter int NPORT = 80,
  parameter int AW    = 7,
  parameter int CW    = 4
) (
  input  logic          clk_cfg,
  input  logic          rst,
  input  logic          en_n,
  input  logic [3:0]    op,
  input  logic [AW-1:0] fa,
  input  logic [AW-1:0] fb,
  input  logic          upd_n,
  output logic [CW:0]   rb,
  output logic          req_vld,
  output logic [2:0]    req_kind,
  output logic [AW-1:0] req_out,
  output logic [AW-1:0] req_in,
  output logic [CW-1:0] req_cfg,
  output logic          bc_on
);

  dec_t          dec;
  logic          a_ok, b_ok, pend;
  logic [CW-1:0] rd_cfg;
  logic          rd_vld;
  logic [AW-1:0] rd_src, bc_src;
  req_kind_e     kind_d;

  xcfg_decode #(.NPORT(NPORT), .AW(AW)) u_dec (
    .en_n(en_n), .op(op), .fa(fa), .fb(fb), .upd_n(upd_n), .pend(pend),
    .dec(dec), .a_ok(a_ok), .b_ok(b_ok)
  );

  xcfg_store #(.NPORT(NPORT), .AW(AW), .CW(CW)) u_store (
    .clk(clk_cfg), .rst(rst), .clr(dec.clr), .bcast(dec.bcast),
    .bufw(dec.bufw), .conn(dec.conn), .disc(dec.disc),
    .rd_first(dec.rd_first), .a_ok(a_ok), .fa(fa), .fb(fb), .upd_n(upd_n),
    .rd_cfg(rd_cfg), .rd_vld(rd_vld), .rd_src(rd_src),
    .bc_on(bc_on), .bc_src(bc_src)
  );

  xcfg_rbseq #(.AW(AW), .CW(CW)) u_rb (
    .clk(clk_cfg), .rst(rst), .en_n(en_n),
    .rd_first(dec.rd_first), .rd_second(dec.rd_second),
    .a_ok(a_ok), .b_ok(b_ok), .fb(fb),
    .rd_cfg(rd_cfg), .rd_vld(rd_vld), .rd_src(rd_src),
    .bc_on(bc_on), .bc_src(bc_src), .pend(pend), .rb(rb)
  );

  always_comb begin
    if (dec.clr)        kind_d = RQ_CLR;
    else if (dec.bcast) kind_d = RQ_BCAST;
    else if (dec.bufw)  kind_d = RQ_BUFW;
    else if (dec.conn)  kind_d = RQ_CONN;
    else if (dec.disc)  kind_d = RQ_DISC;
    else                kind_d = RQ_NONE;
  end

  always_ff @(negedge clk_cfg) begin
    if (rst) begin
      req_vld  <= 1'b0;
      req_kind <= RQ_NONE;
      req_out  <= '0;
      req_in   <= '0;
      req_cfg  <= '0;
    end else begin
      req_vld  <= (kind_d != RQ_NONE);
      req_kind <= kind_d;
      if (kind_d != RQ_NONE) begin
        req_out <= fa;
        req_in  <= fb;
        req_cfg <= fb[CW-1:0];
      end
    end
  end

endmodule

// File: rtl/xcfg_ctrl_chk.sv
module xcfg_ctrl_chk #(
  parameter int NPORT = 80,
  parameter int AW    = 7,
  parameter int CW    = 4
) (
  input logic          clk_cfg,
  input logic          rst,
  input logic          en_n,
  input logic [3:0]    op,
  input logic [AW-1:0] fa,
  input logic          upd_n,
  input logic [CW:0]   rb,
  input logic          req_vld,
  input logic [2:0]    req_kind,
  input logic          bc_on,
  input logic          pend
);

  localparam logic [AW:0] NP = (AW+1)'(NPORT);

  logic cmd;
  logic rsvd;
  assign cmd  = !en_n && !pend;
  assign rsvd = (op == 4'b0000) || (op == 4'b0001) || op[3];

  p_reset_quiet_r1: assert property (@(negedge clk_cfg)
    rst |=> (rb == '0 && !req_vld && !bc_on));

  p_idle_no_req_r2: assert property (@(negedge clk_cfg) disable iff (rst)
    en_n |=> !req_vld);

  p_rsvd_quiet_r3: assert property (@(negedge clk_cfg) disable iff (rst)
    (cmd && rsvd) |=> (!req_vld && rb == '0));

  p_clear_r4: assert property (@(negedge clk_cfg) disable iff (rst)
    (cmd && op == 4'b0010) |=> (req_vld && req_kind == 3'd1 && !bc_on));

  p_update_ends_bc_r6: assert property (@(negedge clk_cfg) disable iff (rst)
    !upd_n |=> !bc_on);

  p_oor_bufw_r11: assert property (@(negedge clk_cfg) disable iff (rst)
    (cmd && op == 4'b0100 && {1'b0, fa} >= NP) |=> !req_vld);

  p_rb_clears_r12: assert property (@(negedge clk_cfg) disable iff (rst)
    cmd |=> rb == '0);

  p_rb_holds_r12: assert property (@(negedge clk_cfg) disable iff (rst)
    en_n |=> $stable(rb));

  p_req_one_cycle_r13: assert property (@(negedge clk_cfg) disable iff (rst)
    (req_vld && en_n) |=> !req_vld);

  p_kind_legal_r13: assert property (@(negedge clk_cfg) disable iff (rst)
    req_vld |-> (req_kind != 3'd0 && req_kind <= 3'd5));

endmodule

bind xcfg_ctrl xcfg_ctrl_chk #(.NPORT(NPORT), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/xcfg_ctrl_bench.sv
module xcfg_ctrl_bench;

  localparam int NP = 80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_n = 1'b1;
  logic [3:0] op = '0;
  logic [6:0] fa = '0, fb = '0;
  logic       upd_n = 1'b1;
  logic [4:0] rb;
  logic       req_vld;
  logic [2:0] req_kind;
  logic [6:0] req_out, req_in;
  logic [3:0] req_cfg;
  logic       bc_on;

  always #5 clk = ~clk;

  xcfg_ctrl u_xcfg_ctrl (
    .clk_cfg(clk), .rst(rst), .en_n(en_n), .op(op), .fa(fa), .fb(fb),
    .upd_n(upd_n), .rb(rb), .req_vld(req_vld), .req_kind(req_kind),
    .req_out(req_out), .req_in(req_in), .req_cfg(req_cfg), .bc_on(bc_on)
  );

  typedef struct {
    logic       vld;
    logic [2:0] kind;
    logic [6:0] out;
    logic [6:0] inp;
    logic [3:0] cfg;
    logic [4:0] rb;
    logic       bc;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  // reference state
  logic [3:0] cfgm [128];
  logic [6:0] srcm [128];
  logic       vldm [128];
  logic       m_bc = 0, m_pend = 0, m_rbok = 0;
  logic [6:0] m_bcsrc = 0, m_rba = 0, m_rbb = 0;
  logic [4:0] m_rb = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e_n, input logic [3:0] o,
                      input logic [6:0] a, input logic [6:0] b,
                      input logic u, input string tag);
    exp_t e;
    logic hit;
    @(posedge clk);
    rst = r; en_n = e_n; op = o; fa = a; fb = b; upd_n = u;
    e.kind = 3'd0; e.out = a; e.inp = b; e.cfg = b[3:0]; e.tag = tag;
    if (r) begin
      for (int i = 0; i < 128; i++) vldm[i] = 1'b0;
      m_bc = 0; m_bcsrc = 0; m_pend = 0; m_rb = 0;
    end else begin
      if (!e_n) begin
        if (m_pend) begin
          m_pend = 0;
          if (m_rbok) begin
            hit  = m_bc ? (m_bcsrc == m_rbb) : (vldm[m_rba] && srcm[m_rba] == m_rbb);
            m_rb = {hit, cfgm[m_rba]};
          end else m_rb = 5'd0;
        end else begin
          m_rb = 5'd0;
          case (o)
            4'd2: begin
              for (int i = 0; i < 128; i++) vldm[i] = 1'b0;
              m_bc = 0; e.kind = 3'd1;
            end
            4'd3: if (u && b < NP) begin m_bc = 1; m_bcsrc = b; e.kind = 3'd2; end
            4'd4: if (a < NP) begin cfgm[a] = b[3:0]; e.kind = 3'd3; end
            4'd5: begin m_pend = 1; m_rba = a; m_rbb = b; m_rbok = (a < NP) && (b < NP); end
            4'd6: if (a < NP && b < NP) begin vldm[a] = 1; srcm[a] = b; e.kind = 3'd4; end
            4'd7: if (a < NP) begin vldm[a] = 0; e.kind = 3'd5; end
            default: ;
          endcase
        end
      end else m_pend = 0;
      if (!u) m_bc = 0;
    end
    e.vld = (e.kind != 3'd0);
    e.rb  = m_rb;
    e.bc  = m_bc;
    q.push_back(e);
  endtask

  task automatic cmd(input logic [3:0] o, input logic [6:0] a, input logic [6:0] b,
                     input string tag);
    step(0, 0, o, a, b, 1, tag);
  endtask

  task automatic rdbk(input logic [6:0] a, input logic [6:0] b, input string tag);
    step(0, 0, 4'd5, a, b, 1, tag);
    step(0, 0, 4'd0, 0, 0, 1, tag);
  endtask

  // monitor: compares the outputs produced by each falling edge
  always @(negedge clk) begin
    #2;
    if (q.size() > 0 && !done) begin
      cur = q.pop_front();
      chk(req_vld === cur.vld, cur.tag, "req_vld", {7'd0, req_vld}, {7'd0, cur.vld});
      chk(rb === cur.rb, cur.tag, "rb", {3'd0, rb}, {3'd0, cur.rb});
      chk(bc_on === cur.bc, cur.tag, "bc_on", {7'd0, bc_on}, {7'd0, cur.bc});
      if (cur.vld) begin
        chk(req_kind === cur.kind, cur.tag, "req_kind R13", {5'd0, req_kind}, {5'd0, cur.kind});
        chk(req_out === cur.out, cur.tag, "req_out R13", {1'b0, req_out}, {1'b0, cur.out});
        chk(req_in === cur.inp, cur.tag, "req_in R13", {1'b0, req_in}, {1'b0, cur.inp});
        chk(req_cfg === cur.cfg, cur.tag, "req_cfg R13", {4'd0, req_cfg}, {4'd0, cur.cfg});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin cfgm[i] = 0; srcm[i] = 0; vldm[i] = 0; end
    step(1, 1, 0, 0, 0, 1, "R1 reset");
    step(1, 1, 0, 0, 0, 1, "R1 reset");
    step(0, 1, 0, 0, 0, 1, "R1 idle");
    cmd(4'd4, 3, 7'h0A, "R7 buffer write");
    cmd(4'd4, 7, 7'h35, "R7 buffer write high bits");
    cmd(4'd4, 79, 7'h0F, "R7 buffer write last port");
    rdbk(3, 5, "R1 no connection after reset");
    cmd(4'd6, 3, 5, "R8 connect");
    rdbk(3, 5, "R9 readback hit");
    step(0, 0, 4'd5, 3, 5, 1, "R9 first");
    step(0, 0, 4'd2, 0, 0, 1, "R9 second cycle opcode ignored");
    rdbk(3, 5, "R9 map kept");
    step(0, 1, 4'd0, 0, 0, 1, "R12 hold across disabled cycle");
    cmd(4'd0, 0, 0, "R3 reserved 0000");
    cmd(4'd1, 3, 9, "R3 reserved 0001");
    cmd(4'd8, 3, 9, "R3 reserved 1000");
    cmd(4'd15, 3, 9, "R3 reserved 1111");
    rdbk(3, 6, "R9 wrong input");
    step(0, 1, 4'd6, 7, 9, 1, "R2 disabled connect");
    rdbk(7, 9, "R2 disabled connect had no effect");
    step(0, 0, 4'd5, 3, 5, 1, "R10 first");
    step(0, 1, 4'd0, 0, 0, 1, "R10 gap");
    cmd(4'd4, 7, 7'h06, "R10 decoded afresh");
    rdbk(7, 9, "R10 new setting");
    step(0, 0, 4'd3, 0, 9, 0, "R6 broadcast with update low");
    cmd(4'd3, 0, 9, "R5 broadcast");
    rdbk(7, 9, "R5 broadcast source");
    rdbk(3, 5, "R5 programmed path hidden");
    cmd(4'd6, 79, 2, "R8 connect during broadcast");
    step(0, 1, 4'd0, 0, 0, 0, "R6 update");
    rdbk(3, 5, "R6 map back");
    rdbk(79, 2, "R6 map back last port");
    cmd(4'd3, 0, 4, "R5 broadcast again");
    cmd(4'd2, 0, 0, "R4 clear");
    rdbk(3, 5, "R4 settings kept");
    rdbk(79, 2, "R4 cleared");
    cmd(4'd6, 3, 5, "R8 reconnect");
    cmd(4'd7, 3, 0, "R8 disconnect");
    rdbk(3, 5, "R8 after disconnect");
    cmd(4'd4, 100, 7'h03, "R11 write A out of range");
    cmd(4'd6, 3, 90, "R11 connect B out of range");
    cmd(4'd6, 80, 3, "R11 connect A at limit");
    cmd(4'd3, 0, 80, "R11 broadcast B at limit");
    cmd(4'd7, 127, 0, "R11 disconnect out of range");
    rdbk(100, 5, "R11 read A out of range");
    rdbk(79, 80, "R11 read B at limit");
    cmd(4'd6, 79, 79, "R11 connect at last port");
    rdbk(79, 79, "R11 readback at last port");
    step(0, 1, 4'd0, 0, 0, 1, "R12 drain");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule